// File: doc/BRIEF.md
# Banked Memory Address Arbiter with Retry Hopper

This block stands between the address sources of a processor complex and a memory split into independently busy banks. Two request ports compete for one issue slot: a central-processor port and a single path shared by all peripheral processors. Each request carries an address and a tag that names the sender, the data destination and the access kind. In every cycle at most one address is broadcast to all banks. The bank selected by the low address bits takes the address only if it is idle. A bank that takes an address stays busy for a fixed number of cycles.

Each issued address enters a hopper, which is a delay line of fixed length. When the entry reaches the end of the line, the outcome is known. An accepted entry is reported on the acceptance port with its tag and then dropped. A rejected entry is issued again in that same cycle, ahead of any new request. This repeats until a bank takes it. The data distributor and the bank arrays are outside this block. A per-bank counter stands in for the busy time of each bank.

Top module: `bank_addr_arbiter`

## Requirements
- R1: After reset no address is issued and nothing is reported accepted. The central-processor port is ready, and the peripheral port is ready while the central-processor port is idle.
- R2: The target bank is the low BANK_W bits of the ADDR_W-bit address, so consecutive addresses map to different banks. A bank holds 2^(ADDR_W-BANK_W) words.
- R3: At most one address is issued per cycle. The issued address and its tag appear on `iss_addr`/`iss_tag` while `iss_valid` is high.
- R4: Issue priority runs from hopper retry, to central processor, to peripheral path. `cpu_ready` is low only while a retry is due. `pp_ready` is low while a retry is due or while `cpu_valid` is high. A request is taken in a cycle where valid and ready are both high.
- R5: An issued address is accepted if its bank is idle in the issue cycle. After accepting, the bank rejects every address during the next BUSY_CYC cycles.
- R6: An accepted address is reported on `acc_valid`/`acc_addr`/`acc_tag` exactly ACC_LAT cycles after its issue cycle.
- R7: A rejected address is issued again exactly ACC_LAT cycles after its rejected issue, with the same tag. This repeats until it is accepted, and an accepted address is never issued again.
- R8: Every request taken from a port is reported accepted exactly once. Its tag is returned unchanged. The tag layout is source id in bits [3:0], destination in [6:4], and access kind in [8:7] (0 read, 1 write, 2 exchange, 3 passed through unchanged).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_valid | input | 1 | Central-processor request present |
| cpu_ready | output | 1 | Central-processor request taken this cycle if valid |
| cpu_addr | input | ADDR_W | Central-processor address |
| cpu_tag | input | 9 | Central-processor tag |
| pp_valid | input | 1 | Shared peripheral request present |
| pp_ready | output | 1 | Peripheral request taken this cycle if valid |
| pp_addr | input | ADDR_W | Peripheral address |
| pp_tag | input | 9 | Peripheral tag |
| iss_valid | output | 1 | Address broadcast to the banks this cycle |
| iss_addr | output | ADDR_W | Broadcast address |
| iss_tag | output | 9 | Tag of the broadcast address |
| acc_valid | output | 1 | An earlier issue was accepted |
| acc_addr | output | ADDR_W | Accepted address |
| acc_tag | output | 9 | Tag of the accepted address |

## Verification
The bench builds the block with 8 banks (BANK_W=3), a busy time of 6 cycles and an acceptance delay of 3 cycles. With these values a busy bank still rejects the first retry of a conflicting address. Several entries are then in the hopper at once, and chains of repeated rejection occur within a few cycles. Random traffic is steered mostly onto three banks so that retries often collide with new central-processor requests and with stalled peripheral requests.

// File: rtl/bka_pkg.sv
// Package: shared tag layout and issue-source encoding for the banked
// address arbiter. Assumes a fixed 9-bit tag, the same on every port.
package bka_pkg;
    localparam int SRC_W  = 4;
    localparam int DST_W  = 3;
    localparam int KIND_W = 2;
    localparam int TAG_W  = SRC_W + DST_W + KIND_W;

    typedef enum logic [KIND_W-1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_XCHG  = 2'd2,
        KIND_RSVD  = 2'd3
    } access_kind_e;

    typedef struct packed {
        access_kind_e         kind;
        logic [DST_W-1:0]     dst;
        logic [SRC_W-1:0]     src;
    } req_tag_t;

    typedef enum logic [1:0] {
        ISRC_NONE  = 2'd0,
        ISRC_RETRY = 2'd1,
        ISRC_CPU   = 2'd2,
        ISRC_PERI  = 2'd3
    } issue_src_e;
endpackage

// File: rtl/bka_issue_select.sv
// Issue selector: picks the single address broadcast this cycle.
// Assumes a due retry always wins, then the central processor, then the
// shared peripheral path. Purely combinational.
module bka_issue_select
    import bka_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              retry_due,
    input  logic [ADDR_W-1:0] retry_addr,
    input  logic [TAG_W-1:0]  retry_tag,
    input  logic              cpu_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [TAG_W-1:0]  cpu_tag,
    input  logic              pp_valid,
    input  logic [ADDR_W-1:0] pp_addr,
    input  logic [TAG_W-1:0]  pp_tag,
    output logic              cpu_ready,
    output logic              pp_ready,
    output logic              sel_valid,
    output logic [ADDR_W-1:0] sel_addr,
    output logic [TAG_W-1:0]  sel_tag,
    output issue_src_e        sel_src
);
    // Readiness: lower-priority sources stall behind higher ones.
    assign cpu_ready = !retry_due;
    assign pp_ready  = !retry_due && !cpu_valid;

    // Fixed-priority choice of the broadcast address.
    always_comb begin
        sel_src  = ISRC_NONE;
        sel_addr = '0;
        sel_tag  = '0;
        if (retry_due) begin
            sel_src  = ISRC_RETRY;
            sel_addr = retry_addr;
            sel_tag  = retry_tag;
        end else if (cpu_valid) begin
            sel_src  = ISRC_CPU;
            sel_addr = cpu_addr;
            sel_tag  = cpu_tag;
        end else if (pp_valid) begin
            sel_src  = ISRC_PERI;
            sel_addr = pp_addr;
            sel_tag  = pp_tag;
        end
    end

    assign sel_valid = (sel_src != ISRC_NONE);
endmodule

// File: rtl/bka_bank_timer.sv
// Bank busy model: one down-counter per bank. A bank that sees an address
// while idle becomes busy for BUSY_CYC cycles. Assumes BUSY_CYC >= 1.
module bka_bank_timer #(
    parameter int BANK_W   = 5,
    parameter int BUSY_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit_valid,
    input  logic [BANK_W-1:0]    hit_bank,
    output logic [(1<<BANK_W)-1:0] bank_free
);
    localparam int NBANK = 1 << BANK_W;
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [CNT_W-1:0] cnt;
        logic             hit_me;

        assign hit_me       = hit_valid && (hit_bank == BANK_W'(g));
        assign bank_free[g] = (cnt == '0);

        // Load on acceptance, otherwise count the busy window down.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt <= '0;
            else if (hit_me && bank_free[g])
                cnt <= CNT_W'(BUSY_CYC);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end

        p_busy_after_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_me && bank_free[g]) |=> !bank_free[g]);
        p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= CNT_W'(BUSY_CYC));
    end
endmodule

// File: rtl/bka_hopper_pipe.sv
// Hopper: fixed-length delay line holding every issued entry until its
// acceptance outcome is due. Assumes DEPTH >= 1; one entry enters and one
// leaves per cycle at most.
module bka_hopper_pipe #(
    parameter int DEPTH = 2,
    parameter int W     = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic [DEPTH-1:0] vld;
    logic [W-1:0]     dat [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        logic         up_v;
        logic [W-1:0] up_d;
        if (s == 0) begin : g_head
            assign up_v = in_valid;
            assign up_d = in_data;
        end else begin : g_body
            assign up_v = vld[s-1];
            assign up_d = dat[s-1];
        end

        // Advance one stage per cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[s] <= 1'b0;
                dat[s] <= '0;
            end else begin
                vld[s] <= up_v;
                dat[s] <= up_d;
            end
        end
    end

    assign out_valid = vld[DEPTH-1];
    assign out_data  = dat[DEPTH-1];

    p_enter_hopper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (vld[0] && dat[0] == $past(in_data)));
endmodule

// File: rtl/bank_addr_arbiter.sv
// Banked memory address arbiter. Broadcasts at most one tagged address per
// cycle, judges acceptance against the target bank's busy state at issue,
// reports the outcome ACC_LAT cycles later and reissues rejects first.
// Assumes requesters hold valid and payload stable until ready.
module bank_addr_arbiter
    import bka_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int BANK_W   = 5,
    parameter int BUSY_CYC = 4,
    parameter int ACC_LAT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [TAG_W-1:0]  cpu_tag,
    input  logic              pp_valid,
    output logic              pp_ready,
    input  logic [ADDR_W-1:0] pp_addr,
    input  logic [TAG_W-1:0]  pp_tag,
    output logic              iss_valid,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [TAG_W-1:0]  iss_tag,
    output logic              acc_valid,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [TAG_W-1:0]  acc_tag
);
    localparam int NBANK = 1 << BANK_W;
    localparam int ENT_W = 1 + TAG_W + ADDR_W;

    logic              hop_valid;
    logic [ENT_W-1:0]  hop_data;
    logic              hop_took;
    logic [TAG_W-1:0]  hop_tag;
    logic [ADDR_W-1:0] hop_addr;
    logic              retry_due;
    issue_src_e        iss_src;
    logic [NBANK-1:0]  bank_free;
    logic [BANK_W-1:0] iss_bank;
    logic              iss_took;

    // Unpack the entry leaving the hopper.
    assign {hop_took, hop_tag, hop_addr} = hop_data;
    assign retry_due = hop_valid && !hop_took;

    bka_issue_select #(.ADDR_W(ADDR_W)) u_sel (
        .retry_due (retry_due),
        .retry_addr(hop_addr),
        .retry_tag (hop_tag),
        .cpu_valid (cpu_valid),
        .cpu_addr  (cpu_addr),
        .cpu_tag   (cpu_tag),
        .pp_valid  (pp_valid),
        .pp_addr   (pp_addr),
        .pp_tag    (pp_tag),
        .cpu_ready (cpu_ready),
        .pp_ready  (pp_ready),
        .sel_valid (iss_valid),
        .sel_addr  (iss_addr),
        .sel_tag   (iss_tag),
        .sel_src   (iss_src)
    );

    // Low address bits pick the bank; outcome is that bank's idle state.
    assign iss_bank = iss_addr[BANK_W-1:0];
    assign iss_took = iss_valid && bank_free[iss_bank];

    bka_bank_timer #(.BANK_W(BANK_W), .BUSY_CYC(BUSY_CYC)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_valid(iss_valid),
        .hit_bank (iss_bank),
        .bank_free(bank_free)
    );

    bka_hopper_pipe #(.DEPTH(ACC_LAT), .W(ENT_W)) u_hopper (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (iss_valid),
        .in_data  ({iss_took, iss_tag, iss_addr}),
        .out_valid(hop_valid),
        .out_data (hop_data)
    );

    // Acceptance report leaves the hopper with the entry.
    assign acc_valid = hop_valid && hop_took;
    assign acc_addr  = hop_addr;
    assign acc_tag   = hop_tag;

    p_retry_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        retry_due |-> (iss_valid && iss_addr == hop_addr && iss_tag == hop_tag
                       && !cpu_ready && !pp_ready));
    p_pp_yields_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |-> !pp_ready);
    p_single_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({retry_due, cpu_valid && cpu_ready, pp_valid && pp_ready}) <= 1);
    p_cpu_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ready) |-> (iss_src == ISRC_CPU && iss_addr == cpu_addr));
endmodule

// File: tb/tb_bank_addr_arbiter.sv
module tb_bank_addr_arbiter;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 18, BW = 3, BUSY = 6, LAT = 3, TW = 9;
    localparam int NB = 1 << BW;

    logic clk = 0, rst_n = 0;
    logic cpu_valid = 0, pp_valid = 0;
    logic [AW-1:0] cpu_addr = '0, pp_addr = '0;
    logic [TW-1:0] cpu_tag = '0, pp_tag = '0;
    logic cpu_ready, pp_ready, iss_valid, acc_valid;
    logic [AW-1:0] iss_addr, acc_addr;
    logic [TW-1:0] iss_tag, acc_tag;

    always #5ns clk = ~clk;

    bank_addr_arbiter #(.ADDR_W(AW), .BANK_W(BW), .BUSY_CYC(BUSY), .ACC_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr), .cpu_tag(cpu_tag),
        .pp_valid(pp_valid), .pp_ready(pp_ready), .pp_addr(pp_addr), .pp_tag(pp_tag),
        .iss_valid(iss_valid), .iss_addr(iss_addr), .iss_tag(iss_tag),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_tag(acc_tag));

    typedef struct { logic [AW-1:0] a; logic [TW-1:0] t; bit took; int due; } item_t;
    item_t q[$];
    int bank_cnt[NB];
    int pend[logic [AW+TW-1:0]];
    int checks = 0, errors = 0, n = 0;
    int sent = 0, accepted = 0, retries = 0;
    bit done = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, n);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Model decisions for the current cycle.
    bit m_head, m_retry, m_took, m_cpu_fire, m_pp_fire;
    int m_src;
    logic [AW-1:0] m_addr;
    logic [TW-1:0] m_tag;

    task automatic eval_and_compare();
        bit exp_cr, exp_pr;
        m_head  = (q.size() > 0) && (q[0].due == n);
        m_retry = m_head && !q[0].took;
        exp_cr = !m_retry;
        exp_pr = !m_retry && !cpu_valid;
        m_src = 0;
        if (m_retry) begin m_src = 1; m_addr = q[0].a; m_tag = q[0].t; end
        else if (cpu_valid) begin m_src = 2; m_addr = cpu_addr; m_tag = cpu_tag; end
        else if (pp_valid) begin m_src = 3; m_addr = pp_addr; m_tag = pp_tag; end
        m_took = (m_src != 0) && (bank_cnt[m_addr[BW-1:0]] == 0);
        m_cpu_fire = cpu_valid && exp_cr;
        m_pp_fire  = pp_valid && exp_pr;
        chk(cpu_ready == exp_cr, "R4", "cpu_ready", cpu_ready, exp_cr);
        chk(pp_ready == exp_pr, "R4", "pp_ready", pp_ready, exp_pr);
        chk(iss_valid == (m_src != 0), "R3", "iss_valid", iss_valid, m_src != 0);
        if (m_src != 0) begin
            chk(iss_addr == m_addr, m_retry ? "R7" : "R3", "iss_addr", iss_addr, m_addr);
            chk(iss_tag == m_tag, m_retry ? "R7" : "R3", "iss_tag", iss_tag, m_tag);
        end
        chk(acc_valid == (m_head && q[0].took), "R5", "acc_valid", acc_valid, m_head && q[0].took);
        if (m_head && q[0].took) begin
            chk(acc_addr == q[0].a, "R6", "acc_addr", acc_addr, q[0].a);
            chk(acc_tag == q[0].t, "R6", "acc_tag", acc_tag, q[0].t);
        end
        if (m_retry) retries++;
        if (acc_valid) begin
            accepted++;
            chk(pend.exists({acc_addr, acc_tag}) && pend[{acc_addr, acc_tag}] > 0,
                "R8", "accepted once", acc_addr, acc_addr);
            if (pend.exists({acc_addr, acc_tag})) pend[{acc_addr, acc_tag}]--;
        end
        if (m_cpu_fire) begin sent++; pend[{cpu_addr, cpu_tag}] = pend.exists({cpu_addr, cpu_tag}) ? pend[{cpu_addr, cpu_tag}] + 1 : 1; end
        if (m_pp_fire)  begin sent++; pend[{pp_addr, pp_tag}] = pend.exists({pp_addr, pp_tag}) ? pend[{pp_addr, pp_tag}] + 1 : 1; end
    endtask

    task automatic update_model();
        item_t it;
        if (m_head) void'(q.pop_front());
        for (int b = 0; b < NB; b++) if (bank_cnt[b] > 0) bank_cnt[b]--;
        if (m_src != 0) begin
            it.a = m_addr; it.t = m_tag; it.took = m_took; it.due = n + LAT;
            q.push_back(it);
            if (m_took) bank_cnt[m_addr[BW-1:0]] = BUSY;
        end
    endtask

    function automatic logic [AW-1:0] rnd_addr();
        logic [BW-1:0] b;
        b = ($urandom % 4 == 0) ? BW'($urandom) : BW'($urandom % 3);
        return {(AW-BW)'($urandom), b};
    endfunction

    task automatic drive_next();
        if (m_cpu_fire) cpu_valid = 0;
        if (m_pp_fire)  pp_valid = 0;
        if (n == 1) begin
            // Directed: both ports target bank 0 in the same cycle.
            cpu_valid = 1; cpu_addr = 18'h00008; cpu_tag = 9'h011;
            pp_valid  = 1; pp_addr  = 18'h00010; pp_tag  = 9'h1A2;
        end else if (n >= 20 && n < 3000) begin
            if (!cpu_valid && $urandom % 100 < 50) begin
                cpu_valid = 1; cpu_addr = rnd_addr(); cpu_tag = TW'($urandom);
            end
            if (!pp_valid && $urandom % 100 < 45) begin
                pp_valid = 1; pp_addr = rnd_addr(); pp_tag = TW'($urandom);
            end
        end
    endtask

    initial begin
        #500us;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        for (int b = 0; b < NB; b++) bank_cnt[b] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(iss_valid == 0, "R1", "iss_valid in reset", iss_valid, 0);
        chk(acc_valid == 0, "R1", "acc_valid in reset", acc_valid, 0);
        chk(cpu_ready == 1, "R1", "cpu_ready in reset", cpu_ready, 1);
        chk(pp_ready == 1, "R1", "pp_ready in reset", pp_ready, 1);
        @(posedge clk); #1ns rst_n = 1;
        n = 0;
        forever begin
            @(negedge clk);
            eval_and_compare();
            // Independent directed expectations for the bank-0 conflict.
            if (n == 1) chk(pp_ready == 0 && iss_addr == 18'h00008, "R4", "cpu before peripheral", iss_addr, 18'h00008);
            if (n == 2) chk(iss_valid && iss_addr == 18'h00010, "R2", "peripheral issue to busy bank 0", iss_addr, 18'h00010);
            if (n == 4) chk(acc_valid && acc_addr == 18'h00008 && acc_tag == 9'h011, "R6", "accept after delay", acc_addr, 18'h00008);
            if (n == 5) chk(iss_valid && iss_addr == 18'h00010 && !cpu_ready && !acc_valid, "R7", "first retry rejected", iss_addr, 18'h00010);
            if (n == 8) chk(iss_valid && iss_addr == 18'h00010, "R5", "retry once bank idle", iss_addr, 18'h00010);
            if (n == 11) chk(acc_valid && acc_addr == 18'h00010 && acc_tag == 9'h1A2, "R7", "retried address accepted", acc_tag, 9'h1A2);
            if (n == 14) chk(!iss_valid, "R7", "no reissue after accept", iss_valid, 0);
            @(posedge clk);
            update_model();
            n++;
            #1ns;
            drive_next();
            if (n > 3000 && q.size() == 0 && !cpu_valid && !pp_valid) break;
            if (n > 20000) break;
        end
        chk(q.size() == 0, "R8", "hopper drained", q.size(), 0);
        chk(sent == accepted, "R8", "requests vs acceptances", accepted, sent);
        begin
            int left = 0;
            foreach (pend[k]) left += pend[k];
            chk(left == 0, "R8", "unaccepted requests", left, 0);
        end
        chk(retries > 0, "R7", "retries exercised", retries, 1);
        finish_run();
    end
endmodule